// File: doc/BRIEF.md
# Single-Wire Pulse-Width Select Shifter

This block drives eight active-low slave selects from one control wire. The controller encodes three commands only in how long it holds the wire low. The block runs on a system clock. It measures each low period and decodes it into one of three actions:

- A long low period sets every select high.
- A short low period shifts a selecting zero into the first output.
- A mid-length low period shifts a deselecting one into the first output.

An eight-bit register holds the select pattern, and its bits drive the outputs directly.

The normal command order is a long pulse, then a short pulse, then a series of mid-length pulses. After the long pulse and the short pulse, output 0 is the only active select. Each mid-length pulse that follows moves the single active select up by one position. The control wire passes through a two-flop synchronizer. Very short lows are treated as glitches and dropped.

Top module: `pulse_select_shifter`

## Requirements
- R1: After reset all eight select outputs `selN` are high (8'hFF).
- R2: A low period of 32 or more synchronized cycles sets `selN` to 8'hFF. This takes effect while the wire is still low, as soon as the low time reaches 32 cycles.
- R3: The rising edge that ends a long (32 or more cycles) low period does not shift anything into the register.
- R4: A low period of 2 to 7 cycles shifts a 0 into `selN[0]` when the pulse ends. Each bit k moves to bit k+1 and bit 7 is discarded.
- R5: A low period of 8 to 31 cycles shifts a 1 into `selN[0]` when the pulse ends, with the same movement of the other bits.
- R6: A low period shorter than 2 cycles leaves `selN` unchanged.
- R7: A long pulse, then one short pulse, then k mid-length pulses (k = 0..7) leaves only `selN[k]` low.
- R8: The low-time counter saturates. A low period of any length above 32 cycles produces exactly one clear, and later pulses decode normally.
- R9: A shift caused by a pulse appears on `selN` at the third rising clock edge that samples the wire high after the pulse, counting that sampling edge as the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlIn | input | 1 | Asynchronous single-wire command input, idle high |
| selN | output | 8 | Active-low select outputs; bit 0 is the first position |

## Verification
The assertions check several properties on every cycle:
- At most one action fires per cycle.
- The low counter never passes its saturation value.
- A clear command is followed by an all-high pattern.
- A shift command moves the pattern by exactly one place.
- The pattern holds when no command is present.
- A one-cycle low never produces a shift.

The bench scenarios are needed for the rest: the exact width boundaries at 2, 8, 31 and 32 cycles, the timing of the clear in the middle of a pulse, the synchronizer latency, and the walk of the active select across all eight outputs.

// File: rtl/pss_pkg.sv
package pss_pkg;
  // Command strobes passed from the width classifier to the select register.
  typedef struct packed {
    logic clearAll;  // set every select high
    logic shiftEn;   // shift one bit into position 0
    logic shiftVal;  // bit value shifted in (0 selects, 1 deselects)
  } selCmd_t;
endpackage

// File: rtl/pss_sync.sv
module pss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  // Chain resets to the idle (high) level so no false low is seen after reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/pss_ctrl.sv
module pss_ctrl
  import pss_pkg::*;
#(
  parameter int GLITCH_MIN = 2,
  parameter int MEDIUM_MIN = 8,
  parameter int WIDE_MIN   = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    lineSync,
  output selCmd_t cmd
);
  localparam int CW = $clog2(WIDE_MIN + 1);
  localparam logic [CW-1:0] WIDE_C   = CW'(WIDE_MIN);
  localparam logic [CW-1:0] PRE_WIDE = CW'(WIDE_MIN - 1);
  localparam logic [CW-1:0] MED_C    = CW'(MEDIUM_MIN);
  localparam logic [CW-1:0] GLT_C    = CW'(GLITCH_MIN);

  logic [CW-1:0] lowCnt;

  // Counts the synchronized low cycles of the current pulse and stops at the wide threshold.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              lowCnt <= '0;
    else if (lineSync)      lowCnt <= '0;
    else if (lowCnt != WIDE_C) lowCnt <= lowCnt + 1'b1;
  end

  // Decodes the pulse width into a command.
  always_comb begin
    cmd = '0;
    if (!lineSync) begin
      if (lowCnt == PRE_WIDE) cmd.clearAll = 1'b1;
    end else if (lowCnt != '0 && lowCnt < WIDE_C) begin
      if (lowCnt >= MED_C) begin
        cmd.shiftEn  = 1'b1;
        cmd.shiftVal = 1'b1;
      end else if (lowCnt >= GLT_C) begin
        cmd.shiftEn  = 1'b1;
        cmd.shiftVal = 1'b0;
      end
    end
  end

  assert_count_saturates_R8: assert property (@(posedge clk) disable iff (!rstN)
    lowCnt <= WIDE_C);

  assert_single_action_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.clearAll, cmd.shiftEn}));

  assert_clear_once_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clearAll |=> !cmd.clearAll);

  assert_glitch_dropped_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lineSync && !$past(lineSync) && $past(lineSync, 2)) |-> !cmd.shiftEn);
endmodule

// File: rtl/pss_shift.sv
module pss_shift
  import pss_pkg::*;
#(
  parameter int NUM_SEL = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  selCmd_t            cmd,
  output logic [NUM_SEL-1:0] selN
);
  logic [NUM_SEL-1:0] selReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             selReg <= '1;
    else if (cmd.clearAll) selReg <= '1;
    else if (cmd.shiftEn)  selReg <= {selReg[NUM_SEL-2:0], cmd.shiftVal};
  end

  assign selN = selReg;

  assert_clear_all_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clearAll |=> (&selN));

  assert_shift_one_place_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.shiftEn && !cmd.clearAll) |=>
      (selN[NUM_SEL-1:1] == $past(selN[NUM_SEL-2:0])) && (selN[0] == $past(cmd.shiftVal)));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.clearAll && !cmd.shiftEn) |=> $stable(selN));
endmodule

// File: rtl/pulse_select_shifter.sv
module pulse_select_shifter
  import pss_pkg::*;
#(
  parameter int NUM_SEL     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int GLITCH_MIN  = 2,
  parameter int MEDIUM_MIN  = 8,
  parameter int WIDE_MIN    = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlIn,
  output logic [NUM_SEL-1:0] selN
);
  logic    lineSync;
  selCmd_t cmd;

  pss_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(ctrlIn), .syncOut(lineSync)
  );

  pss_ctrl #(
    .GLITCH_MIN(GLITCH_MIN), .MEDIUM_MIN(MEDIUM_MIN), .WIDE_MIN(WIDE_MIN)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .lineSync(lineSync), .cmd(cmd)
  );

  pss_shift #(.NUM_SEL(NUM_SEL)) uShift (
    .clk(clk), .rstN(rstN), .cmd(cmd), .selN(selN)
  );

  // While the line is idle high, no clear may reach the register (a clear needs low time).
  assert_clear_needs_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (lineSync && $past(lineSync)) |-> !cmd.clearAll);
endmodule

// File: tb/pulse_select_shifter_test.sv
module pulse_select_shifter_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlIn = 1'b1;
  logic [7:0] selN;

  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;
  string phaseReq = "R1";

  // Behavioural reference model.
  bit         delayQ[$];
  int         lowLen = 0;
  logic [7:0] expSel = 8'hFF;

  pulse_select_shifter uut (.clk(clk), .rstN(rstN), .ctrlIn(ctrlIn), .selN(selN));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) begin
      delayQ = '{1'b1, 1'b1};
      lowLen = 0;
      expSel = 8'hFF;
    end else begin
      bit seen;
      seen = delayQ[0];
      void'(delayQ.pop_front());
      delayQ.push_back(ctrlIn);
      if (!seen) begin
        if (lowLen == 31) expSel = 8'hFF;
        if (lowLen < 32) lowLen++;
      end else begin
        if (lowLen >= 2 && lowLen < 8)       expSel = {expSel[6:0], 1'b0};
        else if (lowLen >= 8 && lowLen < 32) expSel = {expSel[6:0], 1'b1};
        lowLen = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (selN !== expSel) begin
        errors++;
        $display("FAIL %s cycle compare: actual=%h expected=%h", phaseReq, selN, expSel);
      end
    end
  end

  task automatic checkSel(input logic [7:0] want, input string req);
    checks++;
    if (selN !== want) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, selN, want);
    end
  endtask

  task automatic pulse(input int len);
    ctrlIn = 1'b0;
    repeat (len) @(negedge clk);
    ctrlIn = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkSel(8'hFF, "R1");

    phaseReq = "R4"; pulse(4);  checkSel(8'hFE, "R4");
    phaseReq = "R6"; pulse(1);  checkSel(8'hFE, "R6");
    phaseReq = "R5"; pulse(10); checkSel(8'hFD, "R5");
    phaseReq = "R4"; pulse(3);  checkSel(8'hFA, "R4");

    // Clear while the wire is still low, then a quiet trailing edge.
    phaseReq = "R2";
    ctrlIn = 1'b0;
    repeat (37) @(negedge clk);
    checkSel(8'hFF, "R2");
    repeat (3) @(negedge clk);
    ctrlIn = 1'b1;
    phaseReq = "R3";
    repeat (6) @(negedge clk);
    checkSel(8'hFF, "R3");

    // Walk the single active select; lengths cover the short and mid boundaries.
    phaseReq = "R7";
    pulse(2);
    checkSel(8'hFE, "R7");
    for (int k = 1; k < 8; k++) begin
      pulse((k == 1) ? 8 : 8 + k * 3);
      checkSel(~(8'h01 << k), "R7");
    end
    phaseReq = "R5"; pulse(31); checkSel(8'hFF, "R5");
    phaseReq = "R4"; pulse(7);  checkSel(8'hFE, "R4");

    phaseReq = "R8"; pulse(300); checkSel(8'hFF, "R8");
    pulse(5); checkSel(8'hFE, "R8");

    // Latency from the rising edge to the output change.
    phaseReq = "R9";
    ctrlIn = 1'b0;
    repeat (4) @(negedge clk);
    ctrlIn = 1'b1;
    repeat (2) @(negedge clk);
    checkSel(8'hFE, "R9");
    @(negedge clk);
    checkSel(8'hFC, "R9");
    repeat (4) @(negedge clk);

    phaseReq = "R2"; pulse(32); checkSel(8'hFF, "R2");
    phaseReq = "R6"; pulse(4); pulse(1); checkSel(8'hFE, "R6");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule